// File: doc/BRIEF.md
# Comparator Event and Fault Controller

This block is the digital side of an analog comparator. The comparator's raw output bit comes in with no relation to the clock. The block can invert it, then passes it through a synchronizer and watches the result for edges of a chosen polarity. A qualifying edge sets a sticky event flag. Reading the status register clears that flag.

An interrupt request is formed from the flag and a mask bit. Software sets the mask bit and clears it through separate write strobes. A fault output can follow either the event flag or the synchronized comparator level, or it can be forced low.

Input-select, bias-current and hysteresis settings are only stored here and driven out as pins toward the analog macro. A keyed protection register can lock the configuration registers. A write-only control register returns every register and flag to its reset value.

Top module: `cmp_evt_ctrl`

## Requirements
- R1: After reset all registers read 0, and `irq` and `fault` are 0.
- R2: The config register at 0x04 keeps only the bits in mask 0x7777 and reads them back. Its fields are:
  - negative-input select in [2:0]
  - positive-input select in [6:4]
  - enable in [8]
  - edge type in [10:9]
  - invert in [12]
  - fault source in [13]
  - fault enable in [14]
  The two select fields and the enable bit drive `sel_neg`, `sel_pos` and `cmp_on`.
- R3: The analog register at 0x94 keeps only mask 0x07 and drives bit 0 to `bias_fast` and bits [2:1] to `hyst_sel`.
- R4: The edge type selects which edges of the processed level set the flag: 0 sets it on rising edges, 1 on falling edges, 2 on either edge, and 3 on none. With two synchronizer stages, the flag is set at the third rising clock edge after the input changes.
- R5: While the enable bit is 0, no edge sets the flag.
- R6: The status register at 0x30 holds the flag in bit 0, the synchronized processed level in bit 1 and the interrupt mask bit in bit 31. A read of it clears the flag, except when a new edge arrives in the same cycle; the new edge wins.
- R7: Writing bit 0 = 1 at 0x24 sets the mask bit. Writing bit 0 = 1 at 0x28 clears it. Register 0x2C reads the mask bit in bit 0.
- R8: With fault enable at 0, `fault` is 0. With fault enable at 1, `fault` follows the flag when the source bit is 0 and the synchronized level when the source bit is 1.
- R9: `irq` is high exactly when the flag and the mask bit are both 1.
- R10: Writing bit 0 = 1 at 0x00 returns every register, flag and synchronizer stage to the reset state. A write with bit 0 = 0 at 0x00 has no effect.
- R11: A write at 0xE4 updates the lock bit (bit 0) only when bits [31:8] equal 0x414343. Any other value leaves the lock bit unchanged. Reads at 0xE4 return only the lock bit.
- R12: While the lock bit is 1, writes at 0x04 and 0x94 are dropped and set a violation bit, which reads as bit 0 at 0xE8. Reading 0xE8 clears it.
- R13: With invert set, the comparator bit is inverted before synchronization. Both the level and the edge detection see the inverted value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (used for read-to-clear) |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| cmp_raw | input | 1 | Asynchronous comparator output |
| irq | output | 1 | Interrupt request |
| fault | output | 1 | Fault output |
| sel_neg | output | 3 | Negative-input select to analog macro |
| sel_pos | output | 3 | Positive-input select to analog macro |
| cmp_on | output | 1 | Comparator enable to analog macro |
| bias_fast | output | 1 | Bias current select (1 = high speed) |
| hyst_sel | output | 2 | Hysteresis select |

## Verification
The stimulus makes opposite-polarity transitions under every edge type, and it sets edge type 3 together with invert. A detector that decodes the type field wrongly would flag edges it should ignore or miss edges it should catch.

Toggling invert is itself a stimulus: it changes the processed level without any change on the pin. A design that inverted after the detector, or not at all, would produce the wrong flag and the wrong level bit.

The fault source is switched between flag and level, and the mask is cleared while the flag is still set. Read-to-clear of status and of the violation bit is checked by reading each register twice.

The lock is tried with a wrong key in both directions. Soft reset is issued while the lock is active, to show that locked state does not survive it.

// File: rtl/cmp_evt_ctrl.sv
module cmp_evt_ctrl #(
  parameter int          ADDR_W   = 8,
  parameter int          SYNC_LEN = 2,
  parameter logic [23:0] UNLOCK   = 24'h414343
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              cmp_raw,
  output logic              irq,
  output logic              fault,
  output logic [2:0]        sel_neg,
  output logic [2:0]        sel_pos,
  output logic              cmp_on,
  output logic              bias_fast,
  output logic [1:0]        hyst_sel
);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_MSET = ADDR_W'(8'h24);
  localparam logic [ADDR_W-1:0] A_MCLR = ADDR_W'(8'h28);
  localparam logic [ADDR_W-1:0] A_MSK  = ADDR_W'(8'h2C);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] A_ANA  = ADDR_W'(8'h94);
  localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(8'hE4);
  localparam logic [ADDR_W-1:0] A_VIOL = ADDR_W'(8'hE8);
  localparam logic [14:0]       CFG_MASK = 15'h7777;

  logic [14:0]         cfg_q;
  logic [2:0]          ana_q;
  logic                msk_q, flag_q, lock_q, viol_q, prev_q;
  logic [SYNC_LEN-1:0] sync_q;

  wire       cfg_en   = cfg_q[8];
  wire [1:0] cfg_type = cfg_q[10:9];
  wire       cfg_inv  = cfg_q[12];
  wire       cfg_fsrc = cfg_q[13];
  wire       cfg_fen  = cfg_q[14];

  wire level  = sync_q[SYNC_LEN-1];
  wire rise   = level & ~prev_q;
  wire fall   = ~level & prev_q;
  logic edge_hit;
  always_comb begin
    case (cfg_type)
      2'd0:    edge_hit = rise;
      2'd1:    edge_hit = fall;
      2'd2:    edge_hit = rise | fall;
      default: edge_hit = 1'b0;
    endcase
    edge_hit = edge_hit & cfg_en;
  end

  wire soft_rst = bus_wr && bus_addr == A_CTL && bus_wdata[0];
  wire wr_cfg   = bus_wr && bus_addr == A_CFG;
  wire wr_ana   = bus_wr && bus_addr == A_ANA;
  wire bad_wr   = lock_q && (wr_cfg || wr_ana);
  wire rd_stat  = bus_rd && bus_addr == A_STAT;
  wire rd_viol  = bus_rd && bus_addr == A_VIOL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0; ana_q <= '0; msk_q <= 1'b0; flag_q <= 1'b0;
      lock_q <= 1'b0; viol_q <= 1'b0; prev_q <= 1'b0; sync_q <= '0;
    end else if (soft_rst) begin
      cfg_q <= '0; ana_q <= '0; msk_q <= 1'b0; flag_q <= 1'b0;
      lock_q <= 1'b0; viol_q <= 1'b0; prev_q <= 1'b0; sync_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_LEN-2:0], cmp_raw ^ cfg_inv};
      prev_q <= level;
      if (edge_hit)     flag_q <= 1'b1;
      else if (rd_stat) flag_q <= 1'b0;
      if (wr_cfg && !lock_q) cfg_q <= bus_wdata[14:0] & CFG_MASK;
      if (wr_ana && !lock_q) ana_q <= bus_wdata[2:0];
      if (bad_wr)       viol_q <= 1'b1;
      else if (rd_viol) viol_q <= 1'b0;
      if (bus_wr && bus_addr == A_MSET && bus_wdata[0]) msk_q <= 1'b1;
      else if (bus_wr && bus_addr == A_MCLR && bus_wdata[0]) msk_q <= 1'b0;
      if (bus_wr && bus_addr == A_LOCK && bus_wdata[31:8] == UNLOCK)
        lock_q <= bus_wdata[0];
    end
  end

  always_comb begin
    case (bus_addr)
      A_CFG:   bus_rdata = {17'd0, cfg_q};
      A_MSK:   bus_rdata = {31'd0, msk_q};
      A_STAT:  bus_rdata = {msk_q, 29'd0, level, flag_q};
      A_ANA:   bus_rdata = {29'd0, ana_q};
      A_LOCK:  bus_rdata = {31'd0, lock_q};
      A_VIOL:  bus_rdata = {31'd0, viol_q};
      default: bus_rdata = '0;
    endcase
  end

  assign irq       = flag_q & msk_q;
  assign fault     = cfg_fen & (cfg_fsrc ? level : flag_q);
  assign sel_neg   = cfg_q[2:0];
  assign sel_pos   = cfg_q[6:4];
  assign cmp_on    = cfg_en;
  assign bias_fast = ana_q[0];
  assign hyst_sel  = ana_q[2:1];
endmodule

module cmp_evt_ctrl_chk #(
  parameter int          ADDR_W = 8,
  parameter logic [23:0] UNLOCK = 24'h414343
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              irq,
  input logic              fault,
  input logic              flag,
  input logic              msk,
  input logic              en,
  input logic              hit,
  input logic              lock,
  input logic              fen,
  input logic [14:0]       cfg
);
  wire ctl_rst = bus_wr && bus_addr == ADDR_W'(8'h00) && bus_wdata[0];

  AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(en)) else $error("flag set while disabled"); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(8'h30) && !hit) |=> !flag) else $error("flag kept after read"); // R6
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (msk && flag)) else $error("irq without mask"); // R9
  AST_FAULT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !fen |-> !fault) else $error("fault while disabled"); // R8
  AST_KEY_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(8'hE4) && bus_wdata[31:8] != UNLOCK) |=> $stable(lock)) else $error("lock moved on bad key"); // R11
  AST_LOCKED_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && bus_wr && !ctl_rst) |=> $stable(cfg)) else $error("locked config changed"); // R12
endmodule

bind cmp_evt_ctrl cmp_evt_ctrl_chk #(.ADDR_W(ADDR_W), .UNLOCK(UNLOCK)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq(irq), .fault(fault), .flag(flag_q), .msk(msk_q),
  .en(cfg_en), .hit(edge_hit), .lock(lock_q), .fen(cfg_fen), .cfg(cfg_q)
);

// File: tb/cmp_evt_ctrl_bench.sv
`timescale 1ns/100ps
module cmp_evt_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, cmp_raw = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, fault, cmp_on, bias_fast;
  logic [2:0] sel_neg, sel_pos;
  logic [1:0] hyst_sel;

  cmp_evt_ctrl u_cmp_evt_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_raw(cmp_raw), .irq(irq),
    .fault(fault), .sel_neg(sel_neg), .sel_pos(sel_pos), .cmp_on(cmp_on),
    .bias_fast(bias_fast), .hyst_sel(hyst_sel)
  );

  always #2.5 clk = ~clk;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  int          sel_q[$];
  string       tag_q[$];
  logic mon_en = 1'b0;

  // monitor: pops one expected item per armed cycle, samples at negedge
  always @(negedge clk) begin
    if (mon_en && exp_q.size() > 0) begin
      logic [31:0] e, g;
      int s;
      string t;
      e = exp_q.pop_front(); s = sel_q.pop_front(); t = tag_q.pop_front();
      case (s)
        0: g = bus_rdata;
        1: g = {31'd0, irq};
        2: g = {31'd0, fault};
        default: g = {22'd0, sel_pos, sel_neg, cmp_on, bias_fast, hyst_sel};
      endcase
      n_vec++;
      if (g !== e) begin
        n_bad++;
        $display("FAIL %s: got %h expected %h", t, g, e);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick(1);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] e, string t);
    exp_q.push_back(e); sel_q.push_back(0); tag_q.push_back(t);
    bus_rd = 1'b1; bus_addr = a; mon_en = 1'b1;
    tick(1);
    bus_rd = 1'b0; mon_en = 1'b0;
  endtask

  task automatic pin(int s, logic [31:0] e, string t);
    exp_q.push_back(e); sel_q.push_back(s); tag_q.push_back(t);
    mon_en = 1'b1;
    tick(1);
    mon_en = 1'b0;
  endtask

  task automatic drive(logic v);
    cmp_raw = v;
    tick(4);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    rd(8'h04, 32'h0, "R1 config");
    rd(8'h30, 32'h0, "R1 status");
    pin(1, 0, "R1 irq");
    pin(2, 0, "R1 fault");
    // R2 / R3 masks and pins
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, 32'h7777, "R2 config mask");
    pin(3, 32'h3F8, "R2 config pins");
    wr(8'h94, 32'hFF);
    rd(8'h94, 32'h7, "R3 analog mask");
    pin(3, 32'h3FF, "R3 analog pins");
    tick(4);
    rd(8'h30, 32'h2, "R4 type3 no flag, R13 inverted level");
    wr(8'h04, 32'h0);
    tick(4);
    // R7 mask, R4 rising
    wr(8'h04, 32'h100);
    wr(8'h24, 32'h1);
    rd(8'h2C, 32'h1, "R7 mask set");
    drive(1'b1);
    pin(1, 1, "R9 irq with flag and mask");
    rd(8'h30, 32'h8000_0003, "R4 rising flag");
    rd(8'h30, 32'h8000_0002, "R6 read clears");
    pin(1, 0, "R9 irq after clear");
    drive(1'b0);
    rd(8'h30, 32'h8000_0000, "R4 falling ignored in rising mode");
    // falling
    wr(8'h04, 32'h300);
    drive(1'b1);
    rd(8'h30, 32'h8000_0002, "R4 rising ignored in falling mode");
    drive(1'b0);
    rd(8'h30, 32'h8000_0001, "R4 falling flag");
    // any
    wr(8'h04, 32'h500);
    drive(1'b1);
    rd(8'h30, 32'h8000_0003, "R4 any rising");
    drive(1'b0);
    rd(8'h30, 32'h8000_0001, "R4 any falling");
    // disabled
    wr(8'h04, 32'h400);
    drive(1'b1);
    rd(8'h30, 32'h8000_0002, "R5 disabled no flag");
    // invert
    wr(8'h04, 32'h1100);
    tick(4);
    rd(8'h30, 32'h8000_0000, "R13 invert level low");
    drive(1'b0);
    pin(1, 1, "R13 irq on inverted rise");
    rd(8'h30, 32'h8000_0003, "R13 inverted rise flag");
    rd(8'h30, 32'h8000_0002, "R6 cleared again");
    // fault
    wr(8'h04, 32'h7100);
    pin(2, 1, "R8 fault from level");
    wr(8'h04, 32'h3100);
    pin(2, 0, "R8 fault disabled");
    wr(8'h04, 32'h5100);
    pin(2, 0, "R8 fault from clear flag");
    drive(1'b1);
    drive(1'b0);
    pin(2, 1, "R8 fault from set flag");
    // mask clear
    wr(8'h28, 32'h1);
    rd(8'h2C, 32'h0, "R7 mask cleared");
    pin(1, 0, "R9 irq masked");
    rd(8'h30, 32'h3, "R6 status without mask");
    pin(2, 0, "R8 fault follows cleared flag");
    // protection
    wr(8'hE4, 32'h1234_5601);
    rd(8'hE4, 32'h0, "R11 wrong key");
    wr(8'hE4, 32'h4143_4301);
    rd(8'hE4, 32'h1, "R11 right key");
    wr(8'h04, 32'h0);
    rd(8'h04, 32'h5100, "R12 config locked");
    rd(8'hE8, 32'h1, "R12 violation set");
    rd(8'hE8, 32'h0, "R12 violation read clears");
    wr(8'h94, 32'h0);
    rd(8'h94, 32'h7, "R12 analog locked");
    wr(8'hE4, 32'hAAAA_AA00);
    rd(8'hE4, 32'h1, "R11 wrong key cannot unlock");
    // soft reset
    wr(8'h00, 32'h0);
    rd(8'h04, 32'h5100, "R10 no reset on bit0 clear");
    wr(8'h00, 32'h1);
    rd(8'h04, 32'h0, "R10 config reset");
    rd(8'hE4, 32'h0, "R10 lock reset");
    rd(8'h94, 32'h0, "R10 analog reset");
    rd(8'hE8, 32'h0, "R10 violation reset");
    rd(8'h30, 32'h0, "R10 status reset");
    pin(3, 0, "R10 pins reset");
    tick(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule